// File: doc/BRIEF.md
# Ultrasonic Burst Drive Generator

This block produces the excitation burst for an ultrasonic transducer through two low-side drive outputs, A and B. Each output has its own on-time and off-time, counted in system clock cycles, and its own pulse count. A mode setting picks one of three drive styles: output A alone, output B alone, or push-pull, where A and B take turns with a programmable dead time between them. Once the timing is set, a single start strobe launches one burst. A one-cycle done pulse marks the end of the burst.

Timing is loaded through a byte-wide write port. Each 16-bit duration is split into a low byte and a high byte. On start, the block copies the whole configuration into a private snapshot. Writes made while a burst runs therefore change only the next burst. Equal on-time and off-time give a square drive at the transducer's resonant frequency. A pulse count of one gives the short single-shot burst used for close-range echoes.

Top module: `burst_drive_gen`

## Requirements
- R1: After reset, `drive_a`, `drive_b`, `busy` and `done` are low, and every configuration byte reads as zero, so a start with untouched configuration behaves as a zero pulse count.
- R2: With mode code 0 (or the spare code 3, which acts the same), each pulse holds `drive_a` high for the A on-time and then low for the A off-time. The burst repeats for the A pulse count, and `drive_b` stays low.
- R3: With mode code 1, each pulse holds `drive_b` high for the B on-time and then low for the B off-time. The burst repeats for the B pulse count, `drive_a` stays low, and the A count has no effect.
- R4: With mode code 2 (push-pull), each of the A-count repetitions is, in order: A high for the A on-time, both low for the dead time, B high for the B on-time, both low for the dead time. `drive_a` and `drive_b` are never high in the same cycle.
- R5: An on-time, off-time or dead time programmed as zero lasts one cycle.
- R6: When the selected pulse count is zero, no drive output rises, and `done` is high in the cycle right after the cycle in which start was sampled.
- R7: `drive_a` or `drive_b` (whichever the burst starts with) goes high in the cycle after start is sampled. `busy` is high from that cycle until the last phase ends. In the next cycle `done` is high for one cycle, with `busy` and both outputs low.
- R8: A start strobe that arrives while `busy` is high is ignored. The running burst keeps its timing and pulse total.
- R9: Configuration writes during a burst leave that burst unchanged. They apply from the next start.
- R10: Write addresses are: 0/1 A on-time low/high byte, 2/3 A off-time low/high, 4/5 B on-time low/high, 6/7 B off-time low/high, 8 A pulse count, 9 B pulse count, 10 dead time, 11 mode code (bits 1:0). Writes to addresses 12–15 are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all durations count its cycles |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write enable |
| cfg_addr | input | 4 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration byte value |
| start | input | 1 | Launches one burst when the block is idle |
| drive_a | output | 1 | Low-side drive A, high = switch on |
| drive_b | output | 1 | Low-side drive B, high = switch on |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle pulse after the burst ends |

## Verification
Bursts are run in every mode with on-times and off-times that differ from each other, so a swapped duration, a swapped output or a pulse count taken from the wrong output shows up as a misplaced edge. Push-pull runs use unequal A and B on-times and a non-trivial dead time, which exposes phases taken in the wrong order or a dead time missing on either side. Zero durations, zero counts and a 16-bit on-time with a non-zero high byte test the byte assembly and the one-cycle minimum. A start strobe and a configuration rewrite are injected in the middle of a running burst; the unchanged waveform, followed by a changed next burst, separates ignoring the stimulus from acting on it.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int DUR_W    = 16;
    localparam int CNT_W    = 8;
    localparam int DEAD_W   = 8;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int NUM_BYTES = 11;   // byte registers below the mode register

    localparam logic [ADDR_W-1:0] ADDR_ON_A_LO  = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_ON_A_HI  = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_OFF_A_LO = 4'd2;
    localparam logic [ADDR_W-1:0] ADDR_OFF_A_HI = 4'd3;
    localparam logic [ADDR_W-1:0] ADDR_ON_B_LO  = 4'd4;
    localparam logic [ADDR_W-1:0] ADDR_ON_B_HI  = 4'd5;
    localparam logic [ADDR_W-1:0] ADDR_OFF_B_LO = 4'd6;
    localparam logic [ADDR_W-1:0] ADDR_OFF_B_HI = 4'd7;
    localparam logic [ADDR_W-1:0] ADDR_CNT_A    = 4'd8;
    localparam logic [ADDR_W-1:0] ADDR_CNT_B    = 4'd9;
    localparam logic [ADDR_W-1:0] ADDR_DEAD     = 4'd10;
    localparam logic [ADDR_W-1:0] ADDR_MODE     = 4'd11;

    typedef enum logic [1:0] {
        MODE_A_ONLY    = 2'd0,
        MODE_B_ONLY    = 2'd1,
        MODE_PUSH_PULL = 2'd2,
        MODE_SPARE     = 2'd3
    } drive_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_A_ON,
        PH_A_OFF,
        PH_B_ON,
        PH_B_OFF,
        PH_GAP_AB,
        PH_GAP_BA
    } phase_e;

    typedef struct packed {
        logic [DUR_W-1:0]  on_a;
        logic [DUR_W-1:0]  off_a;
        logic [DUR_W-1:0]  on_b;
        logic [DUR_W-1:0]  off_b;
        logic [CNT_W-1:0]  cnt_a;
        logic [CNT_W-1:0]  cnt_b;
        logic [DEAD_W-1:0] dead;
        drive_mode_e       mode;
    } burst_cfg_t;

    // Timer reload for a phase lasting len cycles; zero is stretched to one.
    function automatic logic [DUR_W-1:0] reload_of(input logic [DUR_W-1:0] len);
        return (len == '0) ? '0 : len - 1'b1;
    endfunction

endpackage

// File: rtl/burst_cfg_regs.sv
module burst_cfg_regs
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output burst_cfg_t        cfg
);

    logic [BYTE_W-1:0] bytes_q [NUM_BYTES];
    drive_mode_e       mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BYTES; i++) begin
                bytes_q[i] <= '0;
            end
        end else if (we) begin
            for (int i = 0; i < NUM_BYTES; i++) begin
                if (addr == ADDR_W'(i)) begin
                    bytes_q[i] <= wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_A_ONLY;
        end else if (we && addr == ADDR_MODE) begin
            mode_q <= drive_mode_e'(wdata[1:0]);
        end
    end

    always_comb begin
        cfg.on_a  = {bytes_q[ADDR_ON_A_HI],  bytes_q[ADDR_ON_A_LO]};
        cfg.off_a = {bytes_q[ADDR_OFF_A_HI], bytes_q[ADDR_OFF_A_LO]};
        cfg.on_b  = {bytes_q[ADDR_ON_B_HI],  bytes_q[ADDR_ON_B_LO]};
        cfg.off_b = {bytes_q[ADDR_OFF_B_HI], bytes_q[ADDR_OFF_B_LO]};
        cfg.cnt_a = bytes_q[ADDR_CNT_A];
        cfg.cnt_b = bytes_q[ADDR_CNT_B];
        cfg.dead  = bytes_q[ADDR_DEAD];
        cfg.mode  = mode_q;
    end

endmodule

// File: rtl/burst_phase_timer.sv
module burst_phase_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);

endmodule

// File: rtl/burst_sequencer.sv
module burst_sequencer
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  burst_cfg_t       cfg_live,
    input  logic             timer_zero,
    output logic             timer_load,
    output logic [DUR_W-1:0] timer_val,
    output phase_e           phase,
    output logic             done,
    output burst_cfg_t       run_cfg,
    output logic [CNT_W-1:0] pulses_left
);

    phase_e           phase_q, phase_d;
    burst_cfg_t       run_q, run_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic             done_q, done_d;
    logic             push_pull;
    logic             last_pulse;

    assign push_pull  = (run_q.mode == MODE_PUSH_PULL);
    assign last_pulse = (left_q == CNT_W'(1));

    always_comb begin
        phase_d    = phase_q;
        run_d      = run_q;
        left_d     = left_q;
        done_d     = 1'b0;
        timer_load = 1'b0;
        timer_val  = '0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    run_d = cfg_live;
                    if (cfg_live.mode == MODE_B_ONLY) begin
                        left_d    = cfg_live.cnt_b;
                        timer_val = reload_of(cfg_live.on_b);
                        if (cfg_live.cnt_b != '0) begin
                            phase_d    = PH_B_ON;
                            timer_load = 1'b1;
                        end else begin
                            done_d = 1'b1;
                        end
                    end else begin
                        left_d    = cfg_live.cnt_a;
                        timer_val = reload_of(cfg_live.on_a);
                        if (cfg_live.cnt_a != '0) begin
                            phase_d    = PH_A_ON;
                            timer_load = 1'b1;
                        end else begin
                            done_d = 1'b1;
                        end
                    end
                end
            end
            PH_A_ON: begin
                if (timer_zero) begin
                    timer_load = 1'b1;
                    if (push_pull) begin
                        phase_d   = PH_GAP_AB;
                        timer_val = reload_of(DUR_W'(run_q.dead));
                    end else begin
                        phase_d   = PH_A_OFF;
                        timer_val = reload_of(run_q.off_a);
                    end
                end
            end
            PH_A_OFF: begin
                if (timer_zero) begin
                    if (last_pulse) begin
                        phase_d = PH_IDLE;
                        left_d  = '0;
                        done_d  = 1'b1;
                    end else begin
                        phase_d    = PH_A_ON;
                        left_d     = left_q - 1'b1;
                        timer_load = 1'b1;
                        timer_val  = reload_of(run_q.on_a);
                    end
                end
            end
            PH_GAP_AB: begin
                if (timer_zero) begin
                    phase_d    = PH_B_ON;
                    timer_load = 1'b1;
                    timer_val  = reload_of(run_q.on_b);
                end
            end
            PH_B_ON: begin
                if (timer_zero) begin
                    timer_load = 1'b1;
                    if (push_pull) begin
                        phase_d   = PH_GAP_BA;
                        timer_val = reload_of(DUR_W'(run_q.dead));
                    end else begin
                        phase_d   = PH_B_OFF;
                        timer_val = reload_of(run_q.off_b);
                    end
                end
            end
            PH_B_OFF: begin
                if (timer_zero) begin
                    if (last_pulse) begin
                        phase_d = PH_IDLE;
                        left_d  = '0;
                        done_d  = 1'b1;
                    end else begin
                        phase_d    = PH_B_ON;
                        left_d     = left_q - 1'b1;
                        timer_load = 1'b1;
                        timer_val  = reload_of(run_q.on_b);
                    end
                end
            end
            PH_GAP_BA: begin
                if (timer_zero) begin
                    if (last_pulse) begin
                        phase_d = PH_IDLE;
                        left_d  = '0;
                        done_d  = 1'b1;
                    end else begin
                        phase_d    = PH_A_ON;
                        left_d     = left_q - 1'b1;
                        timer_load = 1'b1;
                        timer_val  = reload_of(run_q.on_a);
                    end
                end
            end
            default: begin
                phase_d = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            run_q   <= '0;
            left_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            run_q   <= run_d;
            left_q  <= left_d;
            done_q  <= done_d;
        end
    end

    assign phase       = phase_q;
    assign done        = done_q;
    assign run_cfg     = run_q;
    assign pulses_left = left_q;

endmodule

// File: rtl/burst_drive_gen.sv
module burst_drive_gen
    import burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [3:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    input  logic       start,
    output logic       drive_a,
    output logic       drive_b,
    output logic       busy,
    output logic       done
);

    burst_cfg_t       cfg_live;
    burst_cfg_t       run_cfg;
    phase_e           phase;
    logic             timer_load;
    logic [DUR_W-1:0] timer_val;
    logic             timer_zero;
    logic [CNT_W-1:0] pulses_left;

    burst_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg_live)
    );

    burst_phase_timer #(.W(DUR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_zero)
    );

    burst_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .cfg_live    (cfg_live),
        .timer_zero  (timer_zero),
        .timer_load  (timer_load),
        .timer_val   (timer_val),
        .phase       (phase),
        .done        (done),
        .run_cfg     (run_cfg),
        .pulses_left (pulses_left)
    );

    assign drive_a = (phase == PH_A_ON);
    assign drive_b = (phase == PH_B_ON);
    assign busy    = (phase != PH_IDLE);

endmodule

// File: rtl/burst_drive_gen_chk.sv
module burst_drive_gen_chk
    import burst_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             drive_a,
    input logic             drive_b,
    input logic             busy,
    input logic             done,
    input burst_cfg_t       run_cfg,
    input logic [CNT_W-1:0] pulses_left,
    input logic             timer_zero
);

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        !(drive_a && drive_b));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !drive_a && !drive_b));

    assert_rise_no_done_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !done);

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !timer_zero) |=> (busy && pulses_left == $past(pulses_left)));

    assert_cfg_held_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(run_cfg));

endmodule

bind burst_drive_gen burst_drive_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .drive_a     (drive_a),
    .drive_b     (drive_b),
    .busy        (busy),
    .done        (done),
    .run_cfg     (run_cfg),
    .pulses_left (pulses_left),
    .timer_zero  (timer_zero)
);

// File: tb/burst_drive_gen_tb.sv
module burst_drive_gen_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       start = 1'b0;
    logic       drive_a, drive_b, busy, done;

    typedef struct {
        logic  a;
        logic  b;
        logic  d;
        logic  bz;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    int   cycles = 0;

    // shadow of the configuration as the requirements define it
    logic [15:0] s_on_a = '0, s_off_a = '0, s_on_b = '0, s_off_b = '0;
    logic [7:0]  s_cnt_a = '0, s_cnt_b = '0, s_dead = '0;
    logic [1:0]  s_mode = '0;

    burst_drive_gen u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .start     (start),
        .drive_a   (drive_a),
        .drive_b   (drive_b),
        .busy      (busy),
        .done      (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: actual cycles %0d expected below %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // monitor: compares one queued item per cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks = checks + 1;
            if (drive_a !== e.a || drive_b !== e.b || done !== e.d || busy !== e.bz) begin
                fails = fails + 1;
                $display("FAIL %s: actual a=%b b=%b done=%b busy=%b expected a=%b b=%b done=%b busy=%b",
                         e.tag, drive_a, drive_b, done, busy, e.a, e.b, e.d, e.bz);
            end
        end
    end

    function automatic int span(input logic [15:0] v);
        return (v == 16'd0) ? 1 : int'(v);
    endfunction

    task automatic push_n(input logic a, input logic b, input logic d, input logic bz,
                          input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.a = a; e.b = b; e.d = d; e.bz = bz; e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    task automatic push_expected(input string tag);
        int n;
        n = (s_mode == 2'd1) ? int'(s_cnt_b) : int'(s_cnt_a);
        for (int p = 0; p < n; p++) begin
            if (s_mode == 2'd1) begin
                push_n(0, 1, 0, 1, tag, span(s_on_b));
                push_n(0, 0, 0, 1, tag, span(s_off_b));
            end else if (s_mode == 2'd2) begin
                push_n(1, 0, 0, 1, tag, span(s_on_a));
                push_n(0, 0, 0, 1, tag, span({8'd0, s_dead}));
                push_n(0, 1, 0, 1, tag, span(s_on_b));
                push_n(0, 0, 0, 1, tag, span({8'd0, s_dead}));
            end else begin
                push_n(1, 0, 0, 1, tag, span(s_on_a));
                push_n(0, 0, 0, 1, tag, span(s_off_a));
            end
        end
        push_n(0, 0, 1, 0, tag, 1);
        push_n(0, 0, 0, 0, tag, 2);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            4'd0:  s_on_a[7:0]   = d;
            4'd1:  s_on_a[15:8]  = d;
            4'd2:  s_off_a[7:0]  = d;
            4'd3:  s_off_a[15:8] = d;
            4'd4:  s_on_b[7:0]   = d;
            4'd5:  s_on_b[15:8]  = d;
            4'd6:  s_off_b[7:0]  = d;
            4'd7:  s_off_b[15:8] = d;
            4'd8:  s_cnt_a = d;
            4'd9:  s_cnt_b = d;
            4'd10: s_dead  = d;
            4'd11: s_mode  = d[1:0];
            default: ;
        endcase
    endtask

    task automatic setup(input logic [15:0] ona, input logic [15:0] offa,
                         input logic [15:0] onb, input logic [15:0] offb,
                         input logic [7:0] ca, input logic [7:0] cb,
                         input logic [7:0] dt, input logic [1:0] md);
        wr(4'd0, ona[7:0]);  wr(4'd1, ona[15:8]);
        wr(4'd2, offa[7:0]); wr(4'd3, offa[15:8]);
        wr(4'd4, onb[7:0]);  wr(4'd5, onb[15:8]);
        wr(4'd6, offb[7:0]); wr(4'd7, offb[15:8]);
        wr(4'd8, ca); wr(4'd9, cb); wr(4'd10, dt); wr(4'd11, {6'd0, md});
    endtask

    task automatic launch(input string tag);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        push_expected(tag);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic burst(input string tag);
        launch(tag);
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs low after reset
        checks = checks + 1;
        if (drive_a !== 1'b0 || drive_b !== 1'b0 || busy !== 1'b0 || done !== 1'b0) begin
            fails = fails + 1;
            $display("FAIL R1: actual a=%b b=%b busy=%b done=%b expected all 0",
                     drive_a, drive_b, busy, done);
        end
        // R1 / R6: untouched configuration means zero count
        burst("R1");

        // R2: A only, unequal on/off, two pulses
        setup(16'd3, 16'd2, 16'd5, 16'd4, 8'd2, 8'd7, 8'd1, 2'd0);
        burst("R2");

        // R3: B only, A count zero has no effect
        setup(16'd6, 16'd6, 16'd1, 16'd4, 8'd0, 8'd3, 8'd1, 2'd1);
        burst("R3");

        // R4: push-pull, unequal on-times, dead time 2
        setup(16'd2, 16'd9, 16'd3, 16'd9, 8'd2, 8'd5, 8'd2, 2'd2);
        burst("R4");

        // R5: zero durations stretched to one cycle, single-ended and push-pull
        setup(16'd0, 16'd0, 16'd0, 16'd0, 8'd3, 8'd1, 8'd0, 2'd0);
        burst("R5");
        wr(4'd11, 8'd2);
        burst("R5");

        // R6: zero count in push-pull and B-only
        setup(16'd4, 16'd4, 16'd4, 16'd4, 8'd0, 8'd0, 8'd1, 2'd2);
        burst("R6");
        wr(4'd11, 8'd1);
        burst("R6");

        // R2 / R10: spare mode acts as A only, 16-bit on-time with high byte
        setup(16'h0105, 16'd3, 16'd2, 16'd2, 8'd1, 8'd4, 8'd1, 2'd3);
        burst("R10");

        // R2: resonant-style square drive, single pulse
        setup(16'h008A, 16'h008A, 16'd1, 16'd1, 8'd1, 8'd0, 8'd0, 2'd0);
        burst("R2");

        // R8: start pulsed in the middle of a burst is ignored
        setup(16'd5, 16'd5, 16'd1, 16'd1, 8'd3, 8'd0, 8'd0, 2'd0);
        launch("R8");
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drain();

        // R9: rewrite configuration during a burst; next burst uses new values
        setup(16'd4, 16'd3, 16'd1, 16'd1, 8'd2, 8'd0, 8'd0, 2'd0);
        launch("R9");
        wr(4'd0, 8'd1);
        wr(4'd8, 8'd1);
        drain();
        burst("R9");

        // R10: writes to unmapped addresses are dropped
        wr(4'd12, 8'hFF);
        wr(4'd15, 8'h03);
        burst("R10");

        // R7: back-to-back launches, each with its own done pulse
        setup(16'd2, 16'd1, 16'd1, 16'd1, 8'd1, 8'd0, 8'd0, 2'd0);
        burst("R7");
        burst("R7");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule